// File: doc/BRIEF.md
# Two-Stage Watchdog Countdown Timer

This block is a system-management watchdog. A down-counter loses one count on every tick of a slow time base, which is divided from the main clock by a parameterized prescaler. With the default settings one tick is 0.6 s. Software keeps the system alive by writing a kick code to the count register. Each kick loads the counter from a programmed initial value.

If software stops kicking, the first pass of the counter ends with a sticky timeout flag and the counter starts again from the initial value. If that flag is still set when the second pass ends, the block records a second-timeout event and sends a one-cycle reset request to the system reset generator. A no-reboot control bit can block this request.

Software reaches the block through a simple register port. Writes take effect on a clock edge. Reads return data combinationally for the selected register. The counter field is 10 bits wide when `WIDE` is 1 and 6 bits wide when `WIDE` is 0. In the text below this width is called CW.

Top module: `wdt_two_stage`

## Requirements
- R1: While the counter runs, it decrements once every `TICK_DIV` clock cycles. A kick restarts the tick phase, so tick k after a kick falls on the k·`TICK_DIV`-th clock edge after the kick edge.
- R2: Writing exactly 0x0001 to selector 0 (count register) is a kick. It loads the counter from the initial-value field. A write of any other value to selector 0 has no effect.
- R3: Reading selector 0 returns the live counter value in bits [CW-1:0] and zero in the bits above.
- R4: Selector 1 (initial-value register) holds the initial-value field in bits [CW-1:0]. The bits above are stored and read back as written. A write whose field is below 4 is ignored entirely.
- R5: Selector 4 bit 11 is the halt bit. While it is 1, the counter keeps its value.
- R6: A tick that arrives while the counter is 0 is an expiry, so expiry falls N+1 ticks after loading N. An expiry reloads the counter from the initial-value field. If selector 2 bit 3 (timeout flag) is clear at the expiry, the expiry sets it.
- R7: An expiry with the timeout flag already set does two things: it sets selector 3 bit 1 (second-timeout flag), and it drives `rst_req` high for exactly one cycle, starting at the expiry edge. When `rst_req` pulses, selector 3 bit 2 (boot flag) is set.
- R8: The status bits in selectors 2 and 3 are write-one-to-clear. Writing a 0 to a status bit leaves it unchanged, and a set in the same cycle wins over a clear.
- R9: Clearing the timeout flag and then kicking restarts the two-pass sequence. The next expiry only sets the timeout flag again.
- R10: While selector 4 bit 0 (no-reboot) is 1, no `rst_req` pulse is produced and the boot flag is not set. The second-timeout flag is still recorded.
- R11: After reset, halt and no-reboot are 1, both the initial value and the counter hold `INIT_DEF` (which is at least 4), and all status flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| sel | input | 3 | Register selector: 0 count, 1 initial value, 2 status 1, 3 status 2, 4 control |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data of the selected register |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench counts clock edges from each kick and samples the flags one edge before and on the edge where expiry is due. A design that treats reaching zero as expiry, or that fails to restart the tick phase on a kick, is off by one tick and fails these checks. The bench runs the second pass twice: once with reboots enabled, where it expects exactly one `rst_req` pulse and the boot flag, and once with no-reboot set, where it expects the flag but no pulse. A design that ignores the no-reboot bit, or that holds the request high for more than one cycle, shows up in the pulse count. The bench also writes illegal initial values, non-kick values to the count register and zero bits to the status registers, and verifies through readback that none of them changed anything. It clears the timeout flag before a kick and expects the next expiry to be a first pass again, which catches a design that keeps stale escalation state.

// File: rtl/wdt_pkg.sv
// Package: register selector codes and bit positions shared by the watchdog.
// Assumes a 16-bit register data path.
package wdt_pkg;

    typedef enum logic [2:0] {
        SEL_COUNT = 3'd0,
        SEL_INIT  = 3'd1,
        SEL_STAT1 = 3'd2,
        SEL_STAT2 = 3'd3,
        SEL_CTRL  = 3'd4
    } reg_sel_e;

    localparam int          DATA_W    = 16;
    localparam int          MIN_INIT  = 4;
    localparam logic [15:0] KICK_CODE = 16'h0001;

    localparam int HALT_BIT = 11;
    localparam int NORB_BIT = 0;
    localparam int TO_BIT   = 3;
    localparam int SEC_BIT  = 1;
    localparam int BOOT_BIT = 2;

endpackage

// File: rtl/wdt_prescaler.sv
// Module: wdt_prescaler
// Divides the main clock into a one-cycle tick every DIV cycles.
// Assumes DIV >= 2. The phase is held at zero while halted, and a restart
// strobe clears it so that the next tick comes DIV cycles later.
module wdt_prescaler #(
    parameter int DIV = 30_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt,
    input  logic restart,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    // Phase counter: wraps at LAST; halt or restart forces it to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (halt || restart) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign tick = !halt && !restart && (phase == LAST);

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R1

endmodule

// File: rtl/wdt_counter.sv
// Module: wdt_counter
// Holds the initial-value register and the down-counter. A write whose field
// is below MIN_INIT is dropped. An expiry is a tick seen at count zero, and it
// reloads the counter on the same edge. A kick has priority over a tick.
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int CW       = 10,
    parameter int INIT_DEF = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic              tick,
    input  logic              kick,
    input  logic              init_we,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CW-1:0]     count,
    output logic [DATA_W-1:0] init_word,
    output logic              expire
);
    localparam logic [CW-1:0]     INIT_RST = CW'(INIT_DEF);
    localparam logic [CW-1:0]     INIT_MIN = CW'(MIN_INIT);

    logic [CW-1:0] init_field;
    logic          init_ok;
    logic          run_tick;

    assign init_field = init_word[CW-1:0];
    assign init_ok    = init_we && (wr_data[CW-1:0] >= INIT_MIN);
    assign run_tick   = tick && !halt;
    assign expire     = run_tick && !kick && (count == '0);

    // Initial-value register: accepts only writes with a legal field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_word <= DATA_W'(INIT_RST);
        end else if (init_ok) begin
            init_word <= wr_data;
        end
    end

    // Down-counter: a kick loads, a tick decrements or reloads on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= INIT_RST;
        end else if (kick) begin
            count <= init_field;
        end else if (run_tick) begin
            if (count == '0) begin
                count <= init_field;
            end else begin
                count <= count - 1'b1;
            end
        end
    end

    AST_RELOAD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (count == $past(init_field))); // R2
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !kick) |=> $stable(count)); // R5
    AST_INIT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        init_we |=> (init_field >= INIT_MIN)); // R4
    AST_EXPIRE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (count == $past(init_field))); // R6

endmodule

// File: rtl/wdt_ctrl_status.sv
// Module: wdt_ctrl_status
// Holds the control bits (halt, no-reboot), the sticky status flags, and the
// escalation rule: a first expiry sets the timeout flag, and an expiry while
// that flag is set records a second timeout and, unless blocked, registers a
// one-cycle reset request. In every flag a set wins over a clear.
module wdt_ctrl_status (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic wr_ctrl,
    input  logic wr_stat1,
    input  logic wr_stat2,
    input  logic d_halt,
    input  logic d_norb,
    input  logic d_to,
    input  logic d_sec,
    input  logic d_boot,
    output logic halt,
    output logic no_reboot,
    output logic to_flag,
    output logic sec_flag,
    output logic boot_flag,
    output logic rst_req
);
    logic first_exp;
    logic second_exp;
    logic fire;

    assign first_exp  = expire && !to_flag;
    assign second_exp = expire && to_flag;
    assign fire       = second_exp && !no_reboot;

    // Control bits: both come out of reset set (stopped, reboot blocked).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt      <= 1'b1;
            no_reboot <= 1'b1;
        end else if (wr_ctrl) begin
            halt      <= d_halt;
            no_reboot <= d_norb;
        end
    end

    // Timeout flag: set by a first expiry, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_flag <= 1'b0;
        end else if (first_exp) begin
            to_flag <= 1'b1;
        end else if (wr_stat1 && d_to) begin
            to_flag <= 1'b0;
        end
    end

    // Second-timeout and boot flags: sticky, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_flag  <= 1'b0;
            boot_flag <= 1'b0;
        end else begin
            if (second_exp) begin
                sec_flag <= 1'b1;
            end else if (wr_stat2 && d_sec) begin
                sec_flag <= 1'b0;
            end
            if (fire) begin
                boot_flag <= 1'b1;
            end else if (wr_stat2 && d_boot) begin
                boot_flag <= 1'b0;
            end
        end
    end

    // Reset request: registered single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
        end else begin
            rst_req <= fire;
        end
    end

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R7
    AST_RST_SETS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (sec_flag && boot_flag)); // R7
    AST_RST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ($past(to_flag) && !$past(no_reboot))); // R10

endmodule

// File: rtl/wdt_two_stage.sv
// Module: wdt_two_stage (top)
// Two-pass watchdog with a register port. Decodes the selector into kick,
// initial-value and control/status write strobes and muxes the read data.
// Assumes INIT_DEF >= 4 and that INIT_DEF fits the counter width.
module wdt_two_stage
    import wdt_pkg::*;
#(
    parameter int WIDE     = 1,
    parameter int TICK_DIV = 30_000_000,
    parameter int INIT_DEF = 50
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  sel,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    output logic        rst_req
);
    localparam int CW = (WIDE != 0) ? 10 : 6;

    reg_sel_e          sel_e;
    logic              kick;
    logic              init_we;
    logic              tick;
    logic              expire;
    logic [CW-1:0]     count;
    logic [DATA_W-1:0] init_word;
    logic              halt;
    logic              no_reboot;
    logic              to_flag;
    logic              sec_flag;
    logic              boot_flag;

    assign sel_e   = reg_sel_e'(sel);
    assign kick    = wr_en && (sel_e == SEL_COUNT) && (wr_data == KICK_CODE);
    assign init_we = wr_en && (sel_e == SEL_INIT);

    wdt_prescaler #(
        .DIV (TICK_DIV)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .halt    (halt),
        .restart (kick),
        .tick    (tick)
    );

    wdt_counter #(
        .CW       (CW),
        .INIT_DEF (INIT_DEF)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt      (halt),
        .tick      (tick),
        .kick      (kick),
        .init_we   (init_we),
        .wr_data   (wr_data),
        .count     (count),
        .init_word (init_word),
        .expire    (expire)
    );

    wdt_ctrl_status u_cs (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire    (expire),
        .wr_ctrl   (wr_en && (sel_e == SEL_CTRL)),
        .wr_stat1  (wr_en && (sel_e == SEL_STAT1)),
        .wr_stat2  (wr_en && (sel_e == SEL_STAT2)),
        .d_halt    (wr_data[HALT_BIT]),
        .d_norb    (wr_data[NORB_BIT]),
        .d_to      (wr_data[TO_BIT]),
        .d_sec     (wr_data[SEC_BIT]),
        .d_boot    (wr_data[BOOT_BIT]),
        .halt      (halt),
        .no_reboot (no_reboot),
        .to_flag   (to_flag),
        .sec_flag  (sec_flag),
        .boot_flag (boot_flag),
        .rst_req   (rst_req)
    );

    // Read mux: places each register's live fields at their bit positions.
    always_comb begin
        rd_data = '0;
        case (sel_e)
            SEL_COUNT: rd_data[CW-1:0]   = count;
            SEL_INIT:  rd_data           = init_word;
            SEL_STAT1: rd_data[TO_BIT]   = to_flag;
            SEL_STAT2: begin
                rd_data[SEC_BIT]  = sec_flag;
                rd_data[BOOT_BIT] = boot_flag;
            end
            SEL_CTRL: begin
                rd_data[HALT_BIT] = halt;
                rd_data[NORB_BIT] = no_reboot;
            end
            default: rd_data = '0;
        endcase
    end

    AST_KICK_ARMS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !tick); // R1

endmodule

// File: tb/sim_wdt_two_stage.sv
module sim_wdt_two_stage;
    localparam int DIV  = 4;
    localparam int IDEF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  sel = 3'd0;
    logic [15:0] wr_data = 16'h0;
    logic [15:0] rd_data;
    logic        rst_req;

    int vectors = 0;
    int errors  = 0;
    int pulses  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    wdt_two_stage #(
        .WIDE     (1),
        .TICK_DIV (DIV),
        .INIT_DEF (IDEF)
    ) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .sel     (sel),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .rst_req (rst_req)
    );

    // Counts reset request pulses, sampled away from the active edge.
    always @(negedge clk) if (rst_n && rst_req) pulses++;

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%04h expected 0x%04h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [15:0] v);
        sel = s;
        #1 v = rd_data;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(3'd4, v); chk("R11", "ctrl after reset", v, 16'h0801);
        rd(3'd1, v); chk("R11", "init after reset", v, 16'(IDEF));
        rd(3'd0, v); chk("R11", "count after reset", v, 16'(IDEF));
        rd(3'd2, v); chk("R11", "stat1 after reset", v, 16'h0000);
        rd(3'd3, v); chk("R11", "stat2 after reset", v, 16'h0000);
        wait_edges(40);
        rd(3'd0, v); chk("R5", "count frozen while halted", v, 16'(IDEF));
    endtask

    task automatic t_init_reg();
        logic [15:0] v;
        wr(3'd1, 16'h0002);
        rd(3'd1, v); chk("R4", "init write of 2 ignored", v, 16'(IDEF));
        wr(3'd1, 16'hA405);
        rd(3'd1, v); chk("R4", "init upper bits kept", v, 16'hA405);
        wr(3'd1, 16'hFC03);
        rd(3'd1, v); chk("R4", "init write of 3 ignored", v, 16'hA405);
        wr(3'd1, 16'h0008);
        rd(3'd1, v); chk("R4", "init legal write", v, 16'h0008);
    endtask

    task automatic t_kick_codes();
        logic [15:0] v;
        wr(3'd0, 16'h0002);
        rd(3'd0, v); chk("R2", "non-kick value no effect", v, 16'(IDEF));
        wr(3'd0, 16'h0001);
        rd(3'd0, v); chk("R2", "kick loads init", v, 16'h0008);
    endtask

    // Runs two passes with reboots enabled: N=8, expiries at 36 and 72 edges.
    task automatic t_two_pass();
        logic [15:0] v;
        wr(3'd4, 16'h0000);
        wr(3'd0, 16'h0001);
        wait_edges(12);
        rd(3'd0, v); chk("R1", "count after 3 ticks", v, 16'h0005);
        chk("R3", "live count upper bits zero", v & 16'hFC00, 16'h0000);
        wait_edges(23);
        rd(3'd2, v); chk("R6", "no flag one edge early", v, 16'h0000);
        rd(3'd0, v); chk("R6", "count at zero before expiry", v, 16'h0000);
        wait_edges(1);
        rd(3'd2, v); chk("R6", "first expiry sets flag", v, 16'h0008);
        rd(3'd0, v); chk("R6", "expiry reloads count", v, 16'h0008);
        chk("R6", "no reset on first pass", 16'(pulses), 16'd0);
        wait_edges(35);
        rd(3'd3, v); chk("R7", "no second flag one edge early", v, 16'h0000);
        chk("R7", "rst_req low one edge early", {15'd0, rst_req}, 16'd0);
        wait_edges(1);
        chk("R7", "rst_req high at second expiry", {15'd0, rst_req}, 16'd1);
        rd(3'd3, v); chk("R7", "second and boot flags", v, 16'h0006);
        wait_edges(1);
        chk("R7", "rst_req one cycle only", {15'd0, rst_req}, 16'd0);
        wr(3'd4, 16'h0800);
        chk("R7", "exactly one pulse", 16'(pulses), 16'd1);
    endtask

    task automatic t_w1c();
        logic [15:0] v;
        wr(3'd2, 16'h0000);
        rd(3'd2, v); chk("R8", "write 0 keeps flag", v, 16'h0008);
        wr(3'd2, 16'h0008);
        rd(3'd2, v); chk("R8", "write 1 clears flag", v, 16'h0000);
        wr(3'd3, 16'h0002);
        rd(3'd3, v); chk("R8", "clear second only", v, 16'h0004);
        wr(3'd3, 16'h0004);
        rd(3'd3, v); chk("R8", "clear boot", v, 16'h0000);
    endtask

    task automatic t_restart();
        logic [15:0] v;
        wr(3'd4, 16'h0000);
        wr(3'd0, 16'h0001);
        wait_edges(36);
        rd(3'd2, v); chk("R9", "first pass flag", v, 16'h0008);
        wr(3'd2, 16'h0008);
        wr(3'd0, 16'h0001);
        wait_edges(35);
        rd(3'd2, v); chk("R9", "flag clear before expiry", v, 16'h0000);
        wait_edges(1);
        rd(3'd2, v); chk("R9", "expiry is first pass again", v, 16'h0008);
        rd(3'd3, v); chk("R9", "no second flag", v, 16'h0000);
        chk("R9", "no new pulse", 16'(pulses), 16'd1);
    endtask

    task automatic t_no_reboot();
        logic [15:0] v;
        wr(3'd4, 16'h0001);
        wr(3'd0, 16'h0001);
        wait_edges(36);
        rd(3'd3, v); chk("R10", "second flag recorded, no boot", v, 16'h0002);
        wait_edges(2);
        chk("R10", "no pulse when blocked", 16'(pulses), 16'd1);
    endtask

    task automatic t_halt();
        logic [15:0] a, b;
        wr(3'd4, 16'h0801);
        rd(3'd0, a);
        wait_edges(30);
        rd(3'd0, b); chk("R5", "count frozen by halt", b, a);
    endtask

    initial begin
        wait_edges(4);
        rst_n = 1'b1;
        t_reset();
        t_init_reg();
        t_kick_codes();
        t_two_pass();
        t_w1c();
        t_restart();
        t_no_reboot();
        t_halt();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule